// File: doc/BRIEF.md
# Double-Buffered Serial-to-Parallel Shift Latch

This block turns a serial bit stream into a parallel word in two stages. A shift chain takes one new bit on every rising edge of its own shift clock. A separate store clock copies the whole chain into a holding register. The parallel outputs show only the holding register. A producer can therefore clock in a complete new word while the outputs keep showing the previous one. It then commits the new word with a single store edge.

An active-low clear empties the shift chain at once, with no clock edge needed, and leaves the holding register untouched. An active-low output enable decides whether the parallel pins drive the held word or float at high impedance. A plain copy of the held word is always available. The last stage of the chain drives a cascade pin, so that units can be chained into longer words. The cascade pin is not gated by the output enable. The width is a parameter and defaults to 8.

Top module: `dbuf_shift_latch`

## Requirements
- R1: On each rising `sh_clk` edge, chain bit 0 takes `ser_in` and chain bit i takes the old value of bit i-1. Bit 0 therefore holds the newest bit. After W shifts sent most-significant bit first, the parallel word equals the value that was sent.
- R2: On each rising `st_clk` edge, the holding register takes the value the shift chain had just before that edge.
- R3: While `clr_n` is 0, every chain bit is 0, with or without a clock edge. `sh_clk` edges have no effect during that time, and the holding register keeps its value.
- R4: With `oe_n` = 1, every `par_out` bit is high impedance. With `oe_n` = 0, `par_out` drives the holding register. `stored_q` always shows the holding register, whatever the value of `oe_n`.
- R5: `casc_out` always equals the last chain bit (bit W-1), whatever the value of `oe_n`.
- R6: When `sh_clk` and `st_clk` rise together, the holding register receives the chain value from before that shared edge, one shift behind the chain.
- R7: With no `st_clk` edge, the holding register and `par_out` do not change, even while the chain shifts. With no `sh_clk` edge and `clr_n` high, the chain does not change.
- R8: Two units can be chained by feeding the `casc_out` of the lower unit into the `ser_in` of the upper unit. After 2W shifts of a word sent most-significant bit first, followed by one shared store edge, {upper `par_out`, lower `par_out`} equals that word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ser_in | input | 1 | Serial data bit taken by chain bit 0 |
| sh_clk | input | 1 | Shift clock, rising edge |
| st_clk | input | 1 | Store clock, rising edge |
| clr_n | input | 1 | Asynchronous active-low clear of the shift chain |
| oe_n | input | 1 | Active-low enable of the parallel pins |
| par_out | output | W | Tri-stateable parallel word from the holding register |
| stored_q | output | W | Holding register, never floated |
| casc_out | output | 1 | Last chain bit, for chaining units |

## Verification
The assertions check on every shift edge that chain bit 0 took the serial bit, that each later bit took its neighbour's old value, and that the cascade pin follows the second-to-last bit one edge later. They also check that the held word changes only when a store edge has occurred and that the enabled parallel pins match the held word. The bench alone shows the floating pins when output is disabled, which it observes through pull-ups. It also covers the clear taking effect between clock edges, the one-shift lag when the two clocks rise together, and a full sweep of every 8-bit value through the chain. Its last scenario shifts whole 16-bit words through two chained units.

// File: rtl/dsl_pkg.sv
package dsl_pkg;
  localparam int unsigned DSL_WIDTH_DEF = 8;

  typedef enum logic {
    OUT_DRIVE = 1'b0,
    OUT_FLOAT = 1'b1
  } oe_mode_e;
endpackage

// File: rtl/dsl_chain.sv
module dsl_chain #(
  parameter int unsigned W = dsl_pkg::DSL_WIDTH_DEF
) (
  input  logic         sh_clk,
  input  logic         clr_n,
  input  logic         ser_in,
  output logic [W-1:0] chain_q
);
  logic [W-1:0] nxt;

  // next value of each stage: head takes the serial bit, others the stage below
  for (genvar i = 0; i < W; i++) begin : g_stage
    if (i == 0) begin : g_head
      assign nxt[i] = ser_in;
    end else begin : g_body
      assign nxt[i] = chain_q[i-1];
    end
  end

  always_ff @(posedge sh_clk or negedge clr_n) begin
    if (!clr_n) chain_q <= '0;
    else        chain_q <= nxt;
  end
endmodule

// File: rtl/dsl_hold.sv
module dsl_hold #(
  parameter int unsigned W = dsl_pkg::DSL_WIDTH_DEF
) (
  input  logic         st_clk,
  input  logic [W-1:0] chain_d,
  output logic [W-1:0] hold_q
);
  // no reset: contents become defined on the first store edge after a clear
  always_ff @(posedge st_clk) begin
    hold_q <= chain_d;
  end
endmodule

// File: rtl/dsl_drive.sv
module dsl_drive #(
  parameter int unsigned W = dsl_pkg::DSL_WIDTH_DEF
) (
  input  logic         oe_n,
  input  logic [W-1:0] hold_d,
  output logic [W-1:0] par_out
);
  import dsl_pkg::*;

  oe_mode_e mode;
  assign mode = oe_mode_e'(oe_n);

  for (genvar i = 0; i < W; i++) begin : g_pin
    assign par_out[i] = (mode == OUT_FLOAT) ? 1'bz : hold_d[i];
  end
endmodule

// File: rtl/dbuf_shift_latch.sv
module dbuf_shift_latch #(
  parameter int unsigned W = dsl_pkg::DSL_WIDTH_DEF
) (
  input  logic         ser_in,
  input  logic         sh_clk,
  input  logic         st_clk,
  input  logic         clr_n,
  input  logic         oe_n,
  output logic [W-1:0] par_out,
  output logic [W-1:0] stored_q,
  output logic         casc_out
);
  localparam int unsigned LAST = W - 1;

  logic [W-1:0] chain_q;
  logic [W-1:0] hold_q;

  dsl_chain #(.W(W)) u_chain (
    .sh_clk (sh_clk),
    .clr_n  (clr_n),
    .ser_in (ser_in),
    .chain_q(chain_q)
  );

  dsl_hold #(.W(W)) u_hold (
    .st_clk (st_clk),
    .chain_d(chain_q),
    .hold_q (hold_q)
  );

  dsl_drive #(.W(W)) u_drive (
    .oe_n   (oe_n),
    .hold_d (hold_q),
    .par_out(par_out)
  );

  assign stored_q = hold_q;
  assign casc_out = chain_q[LAST];
endmodule

// File: rtl/dbuf_shift_latch_chk.sv
module dbuf_shift_latch_chk #(
  parameter int unsigned W = dsl_pkg::DSL_WIDTH_DEF
) (
  input logic         sh_clk,
  input logic         st_clk,
  input logic         clr_n,
  input logic         ser_in,
  input logic         oe_n,
  input logic [W-1:0] chain_q,
  input logic [W-1:0] stored_q,
  input logic [W-1:0] par_out,
  input logic         casc_out
);
  // set by any clear, dropped by the next shift edge
  logic       clr_seen = 1'b1;
  logic [7:0] st_cnt   = 8'd0;

  always_ff @(posedge sh_clk or negedge clr_n) begin
    if (!clr_n) clr_seen <= 1'b1;
    else        clr_seen <= 1'b0;
  end

  always_ff @(posedge st_clk) begin
    st_cnt <= st_cnt + 8'd1;
  end

  // R1
  shift_head_chk: assert property (@(posedge sh_clk) disable iff (!clr_n)
    1'b1 |=> (clr_seen || (chain_q[0] == $past(ser_in))));

  // R1
  shift_body_chk: assert property (@(posedge sh_clk) disable iff (!clr_n)
    1'b1 |=> (clr_seen || (chain_q[W-1:1] == $past(chain_q[W-2:0]))));

  // R5
  casc_follow_chk: assert property (@(posedge sh_clk) disable iff (!clr_n)
    1'b1 |=> (clr_seen || (casc_out == $past(chain_q[W-2]))));

  // R2
  store_copy_chk: assert property (@(posedge st_clk) disable iff (!clr_n)
    1'b1 |=> (stored_q == $past(chain_q)));

  // R3
  clear_zero_chk: assert property (@(posedge sh_clk)
    !clr_n |-> (chain_q == '0));

  // R7
  hold_stable_chk: assert property (@(posedge sh_clk) disable iff (!clr_n)
    1'b1 |=> ((st_cnt != $past(st_cnt)) || $stable(stored_q)));

  // R4
  drive_match_chk: assert property (@(posedge sh_clk) disable iff (!clr_n)
    !oe_n |-> (par_out == stored_q));
endmodule

bind dbuf_shift_latch dbuf_shift_latch_chk #(.W(W)) u_chk (
  .sh_clk  (sh_clk),
  .st_clk  (st_clk),
  .clr_n   (clr_n),
  .ser_in  (ser_in),
  .oe_n    (oe_n),
  .chain_q (chain_q),
  .stored_q(stored_q),
  .par_out (par_out),
  .casc_out(casc_out)
);

// File: tb/dbuf_shift_latch_bench.sv
module dbuf_shift_latch_bench;
  localparam int unsigned W = 8;

  logic clk    = 1'b0;
  logic sh_clk = 1'b0;
  logic st_clk = 1'b0;
  logic clr_n  = 1'b0;
  logic oe_n   = 1'b0;
  logic ser    = 1'b0;

  wire  [W-1:0] par_lo;
  wire  [W-1:0] par_hi;
  logic [W-1:0] sto_lo;
  logic [W-1:0] sto_hi;
  logic         casc_lo;
  logic         casc_hi;

  int checks   = 0;
  int failures = 0;

  always #10 clk = ~clk;

  for (genvar i = 0; i < W; i++) begin : g_pu
    pullup (par_lo[i]);
    pullup (par_hi[i]);
  end

  dbuf_shift_latch #(.W(W)) u_dbuf_shift_latch (
    .ser_in(ser), .sh_clk(sh_clk), .st_clk(st_clk), .clr_n(clr_n),
    .oe_n(oe_n), .par_out(par_lo), .stored_q(sto_lo), .casc_out(casc_lo)
  );

  dbuf_shift_latch #(.W(W)) u_dbuf_shift_latch_hi (
    .ser_in(casc_lo), .sh_clk(sh_clk), .st_clk(st_clk), .clr_n(clr_n),
    .oe_n(oe_n), .par_out(par_hi), .stored_q(sto_hi), .casc_out(casc_hi)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic shift_bit(input logic b);
    @(negedge clk) ser = b;
    @(posedge clk) sh_clk = 1'b1;
    @(negedge clk) sh_clk = 1'b0;
    #1;
  endtask

  task automatic store_pulse();
    @(posedge clk) st_clk = 1'b1;
    @(negedge clk) st_clk = 1'b0;
    #1;
  endtask

  task automatic both_pulse(input logic b);
    @(negedge clk) ser = b;
    @(posedge clk) begin sh_clk = 1'b1; st_clk = 1'b1; end
    @(negedge clk) begin sh_clk = 1'b0; st_clk = 1'b0; end
    #1;
  endtask

  task automatic shift_byte(input logic [7:0] b);
    for (int k = 7; k >= 0; k--) shift_bit(b[k]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0]  prev;
    logic [15:0] words [3];
    words[0] = 16'hBEEF; words[1] = 16'h1234; words[2] = 16'h8001;

    // reset state: clear, release, one store edge
    repeat (3) @(negedge clk);
    clr_n = 1'b1;
    store_pulse();
    check("R3 cleared word", {8'h0, par_lo}, 16'h0);
    check("R5 cleared cascade", {15'h0, casc_lo}, 16'h0);
    check("R4 copy after clear", {8'h0, sto_lo}, 16'h0);

    // sweep every byte: the chain moves, the outputs hold until the store edge
    prev = 8'h00;
    for (int b = 0; b < 256; b++) begin
      for (int k = 1; k <= 8; k++) begin
        int e;
        shift_bit(b[8-k]);
        e = ((int'(prev) << k) | (b >> (8 - k))) & 255;
        check("R1 R5 cascade during shift", {15'h0, casc_lo}, {15'h0, e[7]});
        check("R7 held during shift", {8'h0, par_lo}, {8'h0, prev});
      end
      store_pulse();
      check("R1 R2 word after store", {8'h0, par_lo}, b[15:0]);
      prev = b[7:0];
    end

    // output enable: pins float, copy and cascade stay live
    shift_byte(8'h3C);
    store_pulse();
    @(negedge clk) oe_n = 1'b1;
    #1;
    check("R4 floating pins", {8'h0, par_lo}, 16'h00FF);
    check("R4 copy while floating", {8'h0, sto_lo}, 16'h003C);
    shift_bit(1'b1);
    check("R5 cascade with oe high", {15'h0, casc_lo}, 16'h0);
    shift_bit(1'b1);
    check("R5 cascade with oe high", {15'h0, casc_lo}, 16'h1);
    @(negedge clk) oe_n = 1'b0;
    #1;
    check("R4 driven again", {8'h0, par_lo}, 16'h003C);

    // clear between edges, then shifting under clear
    @(negedge clk) clr_n = 1'b0;
    #1;
    check("R3 async clear cascade", {15'h0, casc_lo}, 16'h0);
    check("R3 storage kept", {8'h0, par_lo}, 16'h003C);
    shift_bit(1'b1);
    check("R3 shift ignored in clear", {15'h0, casc_lo}, 16'h0);
    @(negedge clk) clr_n = 1'b1;
    store_pulse();
    check("R3 chain was zero", {8'h0, par_lo}, 16'h0);

    // both clocks rising together
    shift_byte(8'hA5);
    check("R7 no store edge", {8'h0, par_lo}, 16'h0);
    both_pulse(1'b0);
    check("R6 tied edge one", {8'h0, par_lo}, 16'h00A5);
    both_pulse(1'b1);
    check("R6 tied edge two", {8'h0, par_lo}, 16'h004A);
    store_pulse();
    check("R2 store after tied", {8'h0, par_lo}, 16'h0095);
    store_pulse();
    check("R7 repeated store", {8'h0, par_lo}, 16'h0095);

    // two chained units carry a full word
    for (int w = 0; w < 3; w++) begin
      for (int k = 15; k >= 0; k--) shift_bit(words[w][k]);
      store_pulse();
      check("R8 chained word", {par_hi, par_lo}, words[w]);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule